// File: doc/BRIEF.md
# Fixed Off-Time Current Regulator Sequencer

This block is the digital sequencer for one motor bridge leg pair. It holds motor current near a reference by switching a fixed off-time. While the low-side gate is on, current builds up. An external comparator raises `overCurrent` when the sensed current exceeds the reference. The sequencer then turns the low-side gate off and starts its off-timer.

The off period has four steps. A first guard gap keeps both gates low. The high-side gate then conducts for synchronous rectification, so current recirculates slowly through the upper switches. A second guard gap follows, and then the low-side gate turns on again. Two rules guard the on-phase. A blanking window at the start of each on-phase masks the diode recovery spike. A minimum on-time stops very short pulses.

All four time settings are cycle counts supplied on input ports. The comparator, the sense resistor and the gate drivers are outside the block. A two-bit phase status is brought out for test.

Top module: `toff_current_reg`

## Requirements
- R1: While reset is held, and after reset with `enable` low, `lowGate` and `highGate` are 0 and `phaseState` is 0.
- R2: `phaseState` encodes the step: 0 = on, 1 = first gap, 2 = recirculation, 3 = second gap. The steps follow the order 0,1,2,3,0. While running, `lowGate` is 1 only in step 0 and `highGate` is 1 only in step 2.
- R3: `overCurrent` has no effect during the first `blankCycles` cycles of each on-phase (the cycles with on-phase count below `blankCycles`). A value of 0 disables blanking.
- R4: Each on-phase keeps `lowGate` at 1 for at least `minOnCycles` cycles, even if `overCurrent` is held at 1.
- R5: In an on-phase cycle where `overCurrent` is 1 and both the blanking and minimum-on conditions are met, the on-phase ends at the next edge. Without such a cycle the on-phase continues. With the flag held at 1, the on-phase lasts max(`blankCycles`+1, `minOnCycles`) cycles.
- R6: Each gap step lasts `deadCycles` cycles with both gates at 0.
- R7: The off-timer starts at the trip edge. Recirculation ends once `offCycles` cycles have passed since the trip. For `offCycles` > `deadCycles`, `lowGate` is 0 for `offCycles`+`deadCycles` cycles, and `highGate` is 1 for `offCycles`−`deadCycles` cycles.
- R8: When `offCycles` ≤ `deadCycles`, the recirculation step lasts exactly one cycle.
- R9: `overCurrent` has no effect during steps 1, 2 and 3.
- R10: When `enable` is sampled low, both gates are 0 and `phaseState` is 0 after that edge. After `enable` returns high, a new on-phase starts with its counts restarted. A disable in the same cycle as a trip also leaves step 0.
- R11: `lowGate` and `highGate` are never 1 together, and `gateConflict` stays 0.
- R12: A setting of 0 for `deadCycles`, `offCycles` or `minOnCycles` behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low forces both gates off |
| overCurrent | input | 1 | Comparator flag: current above reference |
| blankCycles | input | 16 | On-phase blanking length in cycles |
| minOnCycles | input | 16 | Minimum on-phase length in cycles |
| deadCycles | input | 16 | Length of each guard gap in cycles |
| offCycles | input | 16 | Off-timer length from trip, in cycles |
| lowGate | output | 1 | Low-side gate enable |
| highGate | output | 1 | High-side gate enable (recirculation) |
| phaseState | output | 2 | Current step, encoded as in R2 |
| gateConflict | output | 1 | Flags both gates on together (design error) |

## Verification
Two pairs of conditions can coincide in one cycle. The first pair is the end of blanking and the end of the minimum on-time. Setting `minOnCycles` = `blankCycles`+1 makes both release in the same on-phase count, and the measured on-phase must then be exactly that length. The second pair is a trip and a disable. Dropping `enable` in a cycle where the flag would trip the phase must leave the sequencer in step 0 with both gates low, not in the first gap. Every sampled cycle is also checked for overlapping gates.

// File: rtl/toffreg_pkg.sv
package toffreg_pkg;

  typedef enum logic [1:0] {
    PH_ON      = 2'd0,
    PH_GAP_OFF = 2'd1,
    PH_RECIRC  = 2'd2,
    PH_GAP_ON  = 2'd3
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrPhase;
    logic clrOff;
  } dpCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic blankOver;
    logic minOnMet;
    logic gapDone;
    logic offDone;
  } dpStat_t;

endpackage

// File: rtl/toffreg_satcnt.sv
module toffreg_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W:0]   cntPlusOne
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntPlusOne = {1'b0, cnt} + 1'b1;
endmodule

// File: rtl/toffreg_dp.sv
module toffreg_dp
  import toffreg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] blankCycles,
  input  logic [CNT_W-1:0] minOnCycles,
  input  logic [CNT_W-1:0] deadCycles,
  input  logic [CNT_W-1:0] offCycles,
  output dpStat_t          stat
);
  localparam int N_CNT   = 2;
  localparam int IDX_PH  = 0;
  localparam int IDX_OFF = 1;

  logic [N_CNT-1:0] clrVec;
  logic [CNT_W:0]   plusOne [N_CNT];

  assign clrVec[IDX_PH]  = cmd.clrPhase;
  assign clrVec[IDX_OFF] = cmd.clrOff;

  generate
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      toffreg_satcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clrVec[g]),
        .cntPlusOne (plusOne[g])
      );
    end
  endgenerate

  // count >= blank  <=>  count+1 > blank
  assign stat.blankOver = plusOne[IDX_PH]  >  {1'b0, blankCycles};
  assign stat.minOnMet  = plusOne[IDX_PH]  >= {1'b0, minOnCycles};
  assign stat.gapDone   = plusOne[IDX_PH]  >= {1'b0, deadCycles};
  assign stat.offDone   = plusOne[IDX_OFF] >= {1'b0, offCycles};
endmodule

// File: rtl/toffreg_ctrl.sv
module toffreg_ctrl
  import toffreg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    overCurrent,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output phase_e  phase,
  output logic    running
);
  phase_e nextPhase;
  logic   trip;

  assign trip = overCurrent && stat.blankOver && stat.minOnMet;

  always_comb begin
    nextPhase    = phase;
    cmd          = '0;
    if (!enable || !running) begin
      nextPhase    = PH_ON;
      cmd.clrPhase = 1'b1;
      cmd.clrOff   = 1'b1;
    end else begin
      unique case (phase)
        PH_ON: if (trip) begin
          nextPhase    = PH_GAP_OFF;
          cmd.clrPhase = 1'b1;
          cmd.clrOff   = 1'b1;
        end
        PH_GAP_OFF: if (stat.gapDone) begin
          nextPhase    = PH_RECIRC;
          cmd.clrPhase = 1'b1;
        end
        PH_RECIRC: if (stat.offDone) begin
          nextPhase    = PH_GAP_ON;
          cmd.clrPhase = 1'b1;
        end
        PH_GAP_ON: if (stat.gapDone) begin
          nextPhase    = PH_ON;
          cmd.clrPhase = 1'b1;
        end
        default: nextPhase = PH_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_ON;
      running <= 1'b0;
    end else begin
      phase   <= nextPhase;
      running <= enable;
    end
  end
endmodule

// File: rtl/toff_current_reg.sv
module toff_current_reg
  import toffreg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             overCurrent,
  input  logic [CNT_W-1:0] blankCycles,
  input  logic [CNT_W-1:0] minOnCycles,
  input  logic [CNT_W-1:0] deadCycles,
  input  logic [CNT_W-1:0] offCycles,
  output logic             lowGate,
  output logic             highGate,
  output logic [1:0]       phaseState,
  output logic             gateConflict
);
  dpCmd_t  cmd;
  dpStat_t stat;
  phase_e  phase;
  logic    running;

  toffreg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .overCurrent (overCurrent),
    .stat        (stat),
    .cmd         (cmd),
    .phase       (phase),
    .running     (running)
  );

  toffreg_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .blankCycles (blankCycles),
    .minOnCycles (minOnCycles),
    .deadCycles  (deadCycles),
    .offCycles   (offCycles),
    .stat        (stat)
  );

  assign lowGate      = running && (phase == PH_ON);
  assign highGate     = running && (phase == PH_RECIRC);
  assign phaseState   = phase;
  assign gateConflict = lowGate && highGate;
endmodule

// File: rtl/toffreg_checker.sv
module toffreg_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] blankCycles,
  input logic [CNT_W-1:0] minOnCycles,
  input logic             lowGate,
  input logic             highGate,
  input logic [1:0]       phaseState,
  input logic             gateConflict
);
  localparam logic [CNT_W:0] LEN_MAX = '1;

  logic [CNT_W:0] onLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                onLen <= '0;
    else if (!lowGate)         onLen <= '0;
    else if (onLen != LEN_MAX) onLen <= onLen + 1'b1;
  end

  p_gates_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lowGate && highGate));

  p_conflict_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gateConflict);

  p_disable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!lowGate && !highGate && phaseState == 2'd0));

  p_phase_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseState != $past(phaseState)) |->
      (phaseState == 2'($past(phaseState) + 2'd1) || phaseState == 2'd0));

  p_high_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(highGate) |-> ($past(phaseState) == 2'd1));

  p_low_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowGate) |-> !$past(highGate));

  p_min_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseState == 2'd1 && $past(phaseState) == 2'd0) |->
      (onLen >= {1'b0, minOnCycles}));

  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseState == 2'd1 && $past(phaseState) == 2'd0) |->
      (onLen > {1'b0, blankCycles}));
endmodule

bind toff_current_reg toffreg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .blankCycles  (blankCycles),
  .minOnCycles  (minOnCycles),
  .lowGate      (lowGate),
  .highGate     (highGate),
  .phaseState   (phaseState),
  .gateConflict (gateConflict)
);

// File: tb/toff_current_reg_bench.sv
`timescale 1ns/1ps
module toff_current_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        overCurrent = 1'b0;
  logic [15:0] blankCycles = '0;
  logic [15:0] minOnCycles = '0;
  logic [15:0] deadCycles = '0;
  logic [15:0] offCycles = '0;
  logic        lowGate, highGate, gateConflict;
  logic [1:0]  phaseState;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  toff_current_reg u_toff_current_reg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .overCurrent(overCurrent),
    .blankCycles(blankCycles), .minOnCycles(minOnCycles),
    .deadCycles(deadCycles), .offCycles(offCycles),
    .lowGate(lowGate), .highGate(highGate),
    .phaseState(phaseState), .gateConflict(gateConflict)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic noOverlap();
    check(!(lowGate && highGate) && !gateConflict, "R11", "gate overlap",
          {lowGate, highGate, gateConflict}, 0);
  endtask

  task automatic setup(input int blank, input int minOn, input int dead,
                       input int off, input bit flag);
    enable = 1'b0;
    step(); step();
    blankCycles = 16'(blank); minOnCycles = 16'(minOn);
    deadCycles = 16'(dead); offCycles = 16'(off);
    overCurrent = flag;
    enable = 1'b1;
    step();
  endtask

  // Measures one full period starting at a sampled first on-phase cycle.
  task automatic period(input int eOn, input int eGa, input int eRe,
                        input int eGb, input string tagOn, input string tagRe);
    int n;
    n = 0;
    while (lowGate && n < 5000) begin
      if (phaseState != 2'd0) check(0, "R2", "phase in on", phaseState, 0);
      noOverlap(); n++; step();
    end
    check(n == eOn, tagOn, "on length", n, eOn);
    n = 0;
    while (!lowGate && !highGate && phaseState == 2'd1 && n < 5000) begin
      n++; step();
    end
    check(n == eGa, "R6", "first gap length", n, eGa);
    n = 0;
    while (highGate && n < 5000) begin
      if (phaseState != 2'd2) check(0, "R2", "phase in recirc", phaseState, 2);
      noOverlap(); n++; step();
    end
    check(n == eRe, tagRe, "recirc length", n, eRe);
    n = 0;
    while (!lowGate && !highGate && phaseState == 2'd3 && n < 5000) begin
      n++; step();
    end
    check(n == eGb, "R6", "second gap length", n, eGb);
    check(lowGate && phaseState == 2'd0, "R2", "back to on", phaseState, 0);
  endtask

  task automatic t_reset();
    step();
    check(!lowGate && !highGate, "R1", "gates in reset", {lowGate, highGate}, 0);
    check(phaseState == 2'd0, "R1", "phase in reset", phaseState, 0);
    rst_n = 1'b1;
    step(); step();
    check(!lowGate && !highGate && phaseState == 2'd0, "R1", "idle after reset",
          {lowGate, highGate, phaseState}, 0);
  endtask

  // flag held high throughout: off-phase flag has no effect (R9)
  task automatic t_basic();
    setup(2, 10, 3, 20, 1'b1);
    period(10, 3, 17, 3, "R4", "R7");
    period(10, 3, 17, 3, "R9", "R9");
  endtask

  task automatic t_blank();
    setup(8, 1, 2, 10, 1'b1);
    period(9, 2, 8, 2, "R3", "R7");
  endtask

  // blanking and minimum on-time release on the same count
  task automatic t_coincide();
    setup(5, 6, 2, 9, 1'b1);
    period(6, 2, 7, 2, "R5", "R7");
  endtask

  task automatic t_blank_pulse();
    setup(10, 1, 2, 6, 1'b0);
    for (int i = 0; i < 12; i++) begin
      overCurrent = (i >= 2 && i <= 5);
      step();
    end
    overCurrent = 1'b0;
    check(lowGate && phaseState == 2'd0, "R3", "pulse in blank ignored",
          {lowGate, phaseState}, 4);
    overCurrent = 1'b1;
    step();
    overCurrent = 1'b0;
    check(!lowGate && phaseState == 2'd1, "R5", "trip after flag",
          {lowGate, phaseState}, 1);
  endtask

  task automatic t_no_flag();
    setup(2, 3, 2, 6, 1'b0);
    repeat (40) step();
    check(lowGate && phaseState == 2'd0, "R5", "stays on without flag",
          {lowGate, phaseState}, 4);
  endtask

  task automatic t_short_off();
    setup(0, 1, 4, 2, 1'b1);
    period(1, 4, 1, 4, "R5", "R8");
  endtask

  task automatic t_zero();
    setup(0, 0, 0, 0, 1'b1);
    period(1, 1, 1, 1, "R12", "R12");
  endtask

  task automatic t_disable();
    int n;
    setup(0, 1, 2, 30, 1'b1);
    n = 0;
    while (!highGate && n < 100) begin n++; step(); end
    step();
    enable = 1'b0;
    step();
    check(!lowGate && !highGate && phaseState == 2'd0, "R10", "disable in recirc",
          {lowGate, highGate, phaseState}, 0);
    step(); step();
    check(!lowGate && !highGate && phaseState == 2'd0, "R10", "stays disabled",
          {lowGate, highGate, phaseState}, 0);
    enable = 1'b1;
    step();
    period(1, 2, 28, 2, "R10", "R10");
    // disable in the very cycle the flag would trip
    setup(0, 3, 2, 6, 1'b0);
    step(); step();
    overCurrent = 1'b1;
    enable = 1'b0;
    step();
    check(!lowGate && !highGate && phaseState == 2'd0, "R10", "disable beats trip",
          {lowGate, highGate, phaseState}, 0);
    overCurrent = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_blank();
    t_coincide();
    t_blank_pulse();
    t_no_flag();
    t_short_off();
    t_zero();
    t_disable();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule